// File: doc/BRIEF.md
# Precise Exception Commit Tracker

This block rides alongside a five-stage in-order pipeline and makes exceptions precise. Any of the four front stages (fetch, decode, execute, memory) may flag a cause code for the instruction it currently holds. The block carries the first cause and the PC of each instruction down the pipe. It decides only at the commit point, the end of the memory stage, whether that instruction is allowed to change state. Exceptions raised out of order are therefore still taken in program order.

When an instruction reaches commit with a cause, the block withholds its register-file and memory write enables and asserts a flush. The flush squashes everything younger. On the next cycle it emits a one-cycle trap pulse that carries the cause and a set of saved restart PCs. With a fixed pair of branch delay slots, three consecutive fetch-order PCs are saved, so a taken branch is not lost when a delay-slot instruction faults. The pulse also tells the front end to fetch from the handler vector. Once an instruction holds a pending exception, the younger instructions that enter behind it are marked dead until the trap has been taken.

Top module: `excCommitTracker`

## Requirements
- R1: While reset is held and in the first cycle after it, `memWe`, `rfWe`, `flush` and `trapValid` are all low.
- R2: Cause codes are 4 bits and 0 means none. Fetch and memory use 1 (page fault), 2 (misaligned) and 3 (protection); decode uses 4 (illegal opcode); execute uses 5 (arithmetic). When one instruction is flagged in several stages, the trap reports the code from the earliest stage.
- R3: An instruction fetched with `ifValid` in cycle c is in the memory stage in cycle c+3. If it is live and has no cause, `memWe` equals `memWeReq` in cycle c+3 and `rfWe` equals the `rfWeReq` of cycle c+3 one cycle later, in c+4.
- R4: A live instruction with a cause produces no `memWe` and no `rfWe`, and `flush` is high in its memory-stage cycle c+3.
- R5: The trap is a single-cycle `trapValid` pulse in cycle c+4 that carries the instruction's cause on `trapCause`.
- R6: Exceptions are taken in program order. After a trapping instruction, the next four instructions in fetch order are killed, up to and including the one fetched during the trap pulse. They produce no writes and no traps, even when one of them was flagged in an earlier cycle than the older fault.
- R7: `trapPcs` holds three PCs in fetch order, slot i at bits [32i+31:32i]. They are the PCs of the faulting instruction and the two fetched after it; for cause 5 they are the PCs of the three instructions fetched after it.
- R8: The instruction fetched in the cycle after the trap pulse (the handler's first) is live: it commits normally, or it traps itself.
- R9: A cause or write request presented in a stage whose instruction has been killed has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ifValid | input | 1 | A fetched instruction is present |
| ifPc | input | 32 | PC of the fetched instruction |
| ifCause | input | 4 | Cause flagged by fetch for that instruction |
| idCause | input | 4 | Cause flagged by decode for its instruction |
| exCause | input | 4 | Cause flagged by execute for its instruction |
| memCause | input | 4 | Cause flagged by memory for its instruction |
| rfWeReq | input | 1 | Memory-stage instruction wants a register write |
| memWeReq | input | 1 | Memory-stage instruction wants a memory write |
| memWe | output | 1 | Committed memory write enable |
| rfWe | output | 1 | Committed register write enable (writeback stage) |
| flush | output | 1 | Kill all instructions younger than the memory stage |
| trapValid | output | 1 | One-cycle trap pulse; fetch the handler vector next |
| trapCause | output | 4 | Cause of the trap being taken |
| trapPcs | output | 96 | Three saved restart PCs, slot 0 lowest |

## Verification
Two things can fall in the same cycle: the commit decision for the instruction in the memory stage, and fresh causes flagged against younger instructions in the earlier stages. The bench provokes this by flagging memory, execute, decode and fetch causes in one cycle on four consecutive instructions. It also lets a younger instruction fault at fetch before an older one faults at memory. In both cases it expects one trap, for the oldest instruction, with its cause and PCs. The younger instructions must show no writes and no traps.

// File: rtl/excCommitPkg.sv
package excCommitPkg;
  localparam int CAUSE_W = 4;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE  = 4'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_PAGE  = 4'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_ALIGN = 4'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_PROT  = 4'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_ILL   = 4'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_ARITH = 4'd5;

  // strobes from control to datapath
  typedef struct packed {
    logic loadId;
    logic loadEx;
    logic loadMem;
    logic commitOk;
    logic take;
    logic resumeAfter;
  } ctrlStrobes_t;
endpackage

// File: rtl/excCommitControl.sv
module excCommitControl
  import excCommitPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                ifValid,
  input  logic                idValid,
  input  logic                exValid,
  input  logic                memValid,
  input  logic                idHas,
  input  logic                exHas,
  input  logic                memHas,
  input  logic [CAUSE_W-1:0]  memEff,
  input  logic                trapValid,
  output ctrlStrobes_t        strobes,
  output logic                flush
);
  logic olderPending;

  // any valid older instruction carrying a cause blocks entries behind it
  assign olderPending = idHas || exHas || memHas;

  always_comb begin
    strobes.loadId      = ifValid && !olderPending && !trapValid;
    strobes.loadEx      = idValid && !exHas && !memHas;
    strobes.loadMem     = exValid && !memHas;
    strobes.commitOk    = memValid && !memHas;
    strobes.take        = memHas;
    strobes.resumeAfter = (memEff == CAUSE_ARITH);
  end

  assign flush = memHas;

  // R5: a flush at commit is followed by the trap pulse
  assert_trap_follows_R5: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> trapValid);
endmodule

// File: rtl/excCommitDatapath.sv
module excCommitDatapath
  import excCommitPkg::*;
#(
  parameter int PC_W  = 32,
  parameter int SAVED = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ifValid,
  input  logic [PC_W-1:0]     ifPc,
  input  logic [CAUSE_W-1:0]  ifCause,
  input  logic [CAUSE_W-1:0]  idCause,
  input  logic [CAUSE_W-1:0]  exCause,
  input  logic [CAUSE_W-1:0]  memCause,
  input  logic                rfWeReq,
  input  logic                memWeReq,
  input  ctrlStrobes_t        strobes,
  output logic                idValid,
  output logic                exValid,
  output logic                memValid,
  output logic                idHas,
  output logic                exHas,
  output logic                memHas,
  output logic [CAUSE_W-1:0]  memEff,
  output logic                memWe,
  output logic                rfWe,
  output logic                trapValid,
  output logic [CAUSE_W-1:0]  trapCause,
  output logic [SAVED*PC_W-1:0] trapPcs
);
  localparam int ORDER_N = SAVED + 1;

  typedef struct packed {
    logic               valid;
    logic [CAUSE_W-1:0] cause;
    logic [PC_W-1:0]    pc;
  } stage_t;

  stage_t idQ, exQ, memQ;
  logic [CAUSE_W-1:0] idEff, exEff;
  logic [PC_W-1:0] orderPc [ORDER_N];

  // the cause flagged earliest wins
  assign idEff  = (idQ.cause  != CAUSE_NONE) ? idQ.cause  : idCause;
  assign exEff  = (exQ.cause  != CAUSE_NONE) ? exQ.cause  : exCause;
  assign memEff = (memQ.cause != CAUSE_NONE) ? memQ.cause : memCause;

  assign idValid  = idQ.valid;
  assign exValid  = exQ.valid;
  assign memValid = memQ.valid;
  assign idHas    = idQ.valid  && (idEff  != CAUSE_NONE);
  assign exHas    = exQ.valid  && (exEff  != CAUSE_NONE);
  assign memHas   = memQ.valid && (memEff != CAUSE_NONE);

  assign memWe = strobes.commitOk && memWeReq;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idQ       <= '0;
      exQ       <= '0;
      memQ      <= '0;
      rfWe      <= 1'b0;
      trapValid <= 1'b0;
      trapCause <= CAUSE_NONE;
    end else begin
      idQ       <= '{valid: strobes.loadId,  cause: ifCause, pc: ifPc};
      exQ       <= '{valid: strobes.loadEx,  cause: idEff,   pc: idQ.pc};
      memQ      <= '{valid: strobes.loadMem, cause: exEff,   pc: exQ.pc};
      rfWe      <= strobes.commitOk && rfWeReq;
      trapValid <= strobes.take;
      if (strobes.take) trapCause <= memEff;
    end
  end

  // fetch-order PCs as seen from the commit point
  always_comb begin
    for (int i = 0; i < ORDER_N; i++) orderPc[i] = '0;
    orderPc[0] = memQ.pc;
    if (ORDER_N > 1) orderPc[1] = exQ.pc;
    if (ORDER_N > 2) orderPc[2] = idQ.pc;
    if (ORDER_N > 3) orderPc[3] = ifPc;
  end

  for (genvar s = 0; s < SAVED; s++) begin : gSave
    always_ff @(posedge clk) begin
      if (!rstN) trapPcs[s*PC_W +: PC_W] <= '0;
      else if (strobes.take)
        trapPcs[s*PC_W +: PC_W] <= strobes.resumeAfter ? orderPc[s+1] : orderPc[s];
    end
  end

  // R5: trap is a single-cycle pulse
  assert_trap_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> !trapValid);
  // R6: taking a trap empties every younger stage
  assert_kill_younger_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.take |=> (!idQ.valid && !exQ.valid && !memQ.valid));
  // R6: the instruction fetched during the pulse is dropped
  assert_pulse_fetch_dead_R6: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |=> !idQ.valid);
  // R4: no memory write from an excepting instruction
  assert_no_mem_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !memHas);
  // R4: register write and trap never come from the same commit
  assert_no_rf_on_trap_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(rfWe && trapValid));
endmodule

// File: rtl/excCommitTracker.sv
module excCommitTracker
  import excCommitPkg::*;
#(
  parameter int PC_W        = 32,
  parameter int DELAY_SLOTS = 2,
  localparam int SAVED      = DELAY_SLOTS + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ifValid,
  input  logic [PC_W-1:0]       ifPc,
  input  logic [3:0]            ifCause,
  input  logic [3:0]            idCause,
  input  logic [3:0]            exCause,
  input  logic [3:0]            memCause,
  input  logic                  rfWeReq,
  input  logic                  memWeReq,
  output logic                  memWe,
  output logic                  rfWe,
  output logic                  flush,
  output logic                  trapValid,
  output logic [3:0]            trapCause,
  output logic [SAVED*PC_W-1:0] trapPcs
);
  ctrlStrobes_t strobes;
  logic idValid, exValid, memValid, idHas, exHas, memHas;
  logic [CAUSE_W-1:0] memEff;

  excCommitDatapath #(.PC_W(PC_W), .SAVED(SAVED)) datapath_i (
    .clk(clk), .rstN(rstN), .ifValid(ifValid), .ifPc(ifPc),
    .ifCause(ifCause), .idCause(idCause), .exCause(exCause), .memCause(memCause),
    .rfWeReq(rfWeReq), .memWeReq(memWeReq), .strobes(strobes),
    .idValid(idValid), .exValid(exValid), .memValid(memValid),
    .idHas(idHas), .exHas(exHas), .memHas(memHas), .memEff(memEff),
    .memWe(memWe), .rfWe(rfWe), .trapValid(trapValid),
    .trapCause(trapCause), .trapPcs(trapPcs)
  );

  excCommitControl control_i (
    .clk(clk), .rstN(rstN), .ifValid(ifValid),
    .idValid(idValid), .exValid(exValid), .memValid(memValid),
    .idHas(idHas), .exHas(exHas), .memHas(memHas), .memEff(memEff),
    .trapValid(trapValid), .strobes(strobes), .flush(flush)
  );
endmodule

// File: tb/excCommitTracker_tb_top.sv
module excCommitTracker_tb_top;
  localparam int N   = 100;
  localparam int TOT = N + 6;
  localparam int SZ  = TOT + 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ifValid = 1'b0;
  logic [31:0] ifPc = '0;
  logic [3:0] ifCause = '0, idCause = '0, exCause = '0, memCause = '0;
  logic rfWeReq = 1'b0, memWeReq = 1'b0;
  logic memWe, rfWe, flush, trapValid;
  logic [3:0] trapCause;
  logic [95:0] trapPcs;

  always #2.5 clk = ~clk;

  excCommitTracker dut_i (
    .clk(clk), .rstN(rstN), .ifValid(ifValid), .ifPc(ifPc),
    .ifCause(ifCause), .idCause(idCause), .exCause(exCause), .memCause(memCause),
    .rfWeReq(rfWeReq), .memWeReq(memWeReq), .memWe(memWe), .rfWe(rfWe),
    .flush(flush), .trapValid(trapValid), .trapCause(trapCause), .trapPcs(trapPcs)
  );

  // program, indexed by fetch cycle
  logic [31:0] pcArr [SZ];
  logic [3:0]  ifC [SZ], idC [SZ], exC [SZ], memC [SZ];
  logic        rfR [SZ], mwR [SZ];
  string       seg [SZ];

  // expectations, indexed by cycle
  logic        eMemWe [SZ], eRfWe [SZ], eFlush [SZ], eTrap [SZ];
  logic [3:0]  eCause [SZ];
  logic [95:0] ePcs [SZ];
  logic        dead [SZ];

  typedef struct {
    int          cyc;
    logic        memWe, rfWe, flush, trap;
    logic [3:0]  cause;
    logic [95:0] pcs;
    string       tag;
  } item_t;
  item_t q[$];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic build();
    for (int c = 0; c < SZ; c++) begin
      pcArr[c] = 32'h1000 + 32'(4 * c);
      ifC[c] = 0; idC[c] = 0; exC[c] = 0; memC[c] = 0;
      rfR[c] = (c < N) && (c % 2 == 0);
      mwR[c] = (c < N) && (c % 3 == 0);
      seg[c] = "R3";
      eMemWe[c] = 0; eRfWe[c] = 0; eFlush[c] = 0; eTrap[c] = 0;
      eCause[c] = 0; ePcs[c] = '0; dead[c] = 0;
    end
    // R4 / R6 / R8: memory page fault, younger ones also request writes
    memC[12] = 4'd1;
    for (int c = 12; c < 18; c++) begin rfR[c] = 1; mwR[c] = 1; end
    for (int c = 12; c < 20; c++) seg[c] = "R6";
    seg[17] = "R8";
    // R7: arithmetic fault resumes after, PCs follow a taken branch
    exC[22] = 4'd5;
    pcArr[24] = 32'h2000; pcArr[25] = 32'h2004; pcArr[26] = 32'h2008;
    for (int c = 22; c < 28; c++) seg[c] = "R7";
    // R6: four stages flag in one cycle
    memC[31] = 4'd3; exC[32] = 4'd5; idC[33] = 4'd4; ifC[34] = 4'd1;
    for (int c = 31; c < 38; c++) seg[c] = "R6";
    // R2: fetch and memory both flag one instruction
    ifC[42] = 4'd2; memC[42] = 4'd3;
    for (int c = 42; c < 48; c++) seg[c] = "R2";
    // R9: younger faults earlier than older, killed stages flagged
    memC[52] = 4'd1; ifC[53] = 4'd3; idC[54] = 4'd4; exC[55] = 4'd5;
    for (int c = 52; c < 58; c++) seg[c] = "R9";
    // R8: handler's first instruction faults at once
    idC[61] = 4'd4; ifC[66] = 4'd1;
    for (int c = 61; c < 72; c++) seg[c] = "R8";
    // R7: restart at the faulting instruction across a branch
    memC[74] = 4'd2; pcArr[75] = 32'h4000; pcArr[76] = 32'h5000;
    for (int c = 74; c < 80; c++) seg[c] = "R7";

    // model from the requirements
    for (int k = 0; k < TOT; k++) begin
      if (!dead[k]) begin
        logic [3:0] cz;
        int off;
        cz = (ifC[k] != 0) ? ifC[k] : (idC[k] != 0) ? idC[k] : (exC[k] != 0) ? exC[k] : memC[k];
        if (cz != 0) begin
          eFlush[k+3] = 1; eTrap[k+4] = 1; eCause[k+4] = cz;
          off = (cz == 4'd5) ? 1 : 0;
          for (int i = 0; i < 3; i++) ePcs[k+4][i*32 +: 32] = pcArr[k+off+i];
          for (int j = 1; j <= 4; j++) dead[k+j] = 1;
        end else begin
          eMemWe[k+3] = mwR[k]; eRfWe[k+4] = rfR[k];
        end
      end
    end
  endtask

  // monitor: pop and compare
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        string t;
        it = q.pop_front();
        t = it.tag;
        chk(t, $sformatf("memWe c%0d", it.cyc), 96'(memWe), 96'(it.memWe));
        chk(t, $sformatf("rfWe c%0d", it.cyc), 96'(rfWe), 96'(it.rfWe));
        chk((it.flush || flush) ? "R4" : t, $sformatf("flush c%0d", it.cyc), 96'(flush), 96'(it.flush));
        chk((it.trap || trapValid) ? "R5" : t, $sformatf("trapValid c%0d", it.cyc), 96'(trapValid), 96'(it.trap));
        if (it.trap) begin
          chk("R2", $sformatf("trapCause c%0d", it.cyc), 96'(trapCause), 96'(it.cause));
          chk("R7", $sformatf("trapPcs c%0d", it.cyc), trapPcs, it.pcs);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    build();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset memWe", 96'(memWe), 96'(0));
    chk("R1", "reset rfWe", 96'(rfWe), 96'(0));
    chk("R1", "reset flush", 96'(flush), 96'(0));
    chk("R1", "reset trapValid", 96'(trapValid), 96'(0));
    rstN = 1'b1;
    for (int c = 0; c < TOT + 2; c++) begin
      item_t it;
      @(posedge clk);
      #1;
      ifValid  = 1'b1;
      ifPc     = pcArr[c];
      ifCause  = ifC[c];
      idCause  = (c >= 1) ? idC[c-1] : 4'd0;
      exCause  = (c >= 2) ? exC[c-2] : 4'd0;
      memCause = (c >= 3) ? memC[c-3] : 4'd0;
      rfWeReq  = (c >= 3) ? rfR[c-3] : 1'b0;
      memWeReq = (c >= 3) ? mwR[c-3] : 1'b0;
      it.cyc = c; it.memWe = eMemWe[c]; it.rfWe = eRfWe[c]; it.flush = eFlush[c];
      it.trap = eTrap[c]; it.cause = eCause[c]; it.pcs = ePcs[c];
      it.tag = (c == 0) ? "R1" : (c >= 4) ? seg[c-4] : "R3";
      q.push_back(it);
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule